// File: doc/BRIEF.md
# Indexed Clock-Chip Register Port

This block is the host side of a real-time-clock register file. A host sees only two byte locations: an even one that selects a location inside a 128-byte space, and an odd one that reads or writes the selected location. Four locations hold control and status: two control registers (here called CTLA and CTLB), one event-status register (EVST) and one constant validity register (VLD). All other locations behave as plain byte storage.

Neighbouring blocks feed in single-cycle strobes. The timekeeping block marks the start and end of an update window and reports update-ended and alarm-match events. The periodic-rate block reports periodic ticks. The block turns these into status flags and one interrupt line, and exposes the control fields so those neighbours can read their settings. A synchronous power-up reset loads the initial register values. A separate soft reset clears the interrupt enables and the pending flags.

Top module: `rtcp_regport`

## Requirements
- R1: A host write to the even location loads the index from data bits 6:0, and bit 7 is dropped. A write to the odd location stores the byte at the indexed location, and a read of the odd location returns it in the same cycle.
- R2: A host read of the even location returns 0xFF.
- R3: CTLA (index 10) bit 7 is the update-in-progress flag, and host writes cannot change it; bits 6:0 are writable. The flag is set by `uip_set` while CTLB bit 7 is 0 and cleared by `uip_clr`.
- R4: Host writes to EVST (index 12) and VLD (index 13) leave them unchanged; VLD always reads 0x80.
- R5: A CTLB (index 11) write with data bit 7 = 1 clears the update-in-progress flag and stores bit 4 as 0, so `set_mode` high implies `uie_en` low.
- R6: An odd read with index 12 returns EVST, then EVST becomes 0x00 and `irq` is low from the next cycle.
- R7: After power-up reset CTLA = 0x26, CTLB = 0x02, EVST = 0x00, VLD = 0x80, `irq` = 0.
- R8: `soft_rst` clears CTLB bits 6, 5 and 3, clears EVST flag bits 7:4, and lowers `irq`.
- R9: EVST layout is bit7 = any-interrupt, bit6 = periodic, bit5 = alarm, bit4 = update-ended. `uf_set` always sets bit 4 and sets bit 7 if CTLB bit 4 is set. `pf_set` sets bits 6 and 7 only if CTLB bit 6 is set. `af_set` sets bits 5 and 7 only if CTLB bit 5 is set. `irq` equals bit 7.
- R10: A flag strobe in the same cycle as an EVST read survives the clear. The read returns the old value, and the new flag and `irq` are present on the next cycle.
- R11: The outputs reflect the stored fields. `rate_sel` is CTLA[3:0] and `osc_sel` is CTLA[6:4]. From CTLB: `set_mode` is bit 7, `pie_en` bit 6, `aie_en` bit 5, `uie_en` bit 4, `sqw_en` bit 3, `bin_mode` bit 2, `hr24_mode` bit 1, `dst_en` bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous power-up reset, active high |
| soft_rst | input | 1 | Synchronous soft reset of enables and flags |
| bus_wr | input | 1 | Host write strobe |
| bus_rd | input | 1 | Host read strobe |
| bus_odd | input | 1 | 0 selects the index location, 1 the data location |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Host read data (combinational) |
| uip_set | input | 1 | Update window starting |
| uip_clr | input | 1 | Update window ended |
| uf_set | input | 1 | Update-ended event |
| af_set | input | 1 | Alarm-match event |
| pf_set | input | 1 | Periodic tick event |
| rate_sel | output | 4 | Periodic rate field |
| osc_sel | output | 3 | Oscillator/divider field |
| set_mode | output | 1 | Time-setting mode (updates held off) |
| pie_en | output | 1 | Periodic interrupt enable |
| aie_en | output | 1 | Alarm interrupt enable |
| uie_en | output | 1 | Update-ended interrupt enable |
| sqw_en | output | 1 | Square-wave output enable |
| bin_mode | output | 1 | Binary (1) or BCD (0) data format |
| hr24_mode | output | 1 | 24-hour format |
| dst_en | output | 1 | Daylight-saving enable |
| uip | output | 1 | Update-in-progress flag |
| irq | output | 1 | Interrupt line, active high |

## Verification
The checker assumes that every event input is a single-cycle strobe and that the host asserts at most one of read or write in a cycle. It also assumes that `uip_set` and `uip_clr` never arrive together with a CTLA write. The directed stimulus follows these rules, with one exception: the same-cycle collision of an event strobe and an EVST read is produced on purpose. The interrupt-drop property is therefore written to exclude cycles in which any strobe is active.

// File: rtl/rtcp_pkg.sv
package rtcp_pkg;
    localparam int DW      = 8;
    localparam int IDX_W   = 7;
    localparam int DEPTH   = 1 << IDX_W;

    localparam logic [IDX_W-1:0] IDX_CTLA = 7'd10;
    localparam logic [IDX_W-1:0] IDX_CTLB = 7'd11;
    localparam logic [IDX_W-1:0] IDX_EVST = 7'd12;
    localparam logic [IDX_W-1:0] IDX_VLD  = 7'd13;

    localparam logic [DW-1:0] CTLA_INIT = 8'h26;
    localparam logic [DW-1:0] CTLB_INIT = 8'h02;
    localparam logic [DW-1:0] VLD_VAL   = 8'h80;
    localparam logic [DW-1:0] IDX_READ  = 8'hFF;

    // control-B bit positions
    localparam int B_SET  = 7;
    localparam int B_PIE  = 6;
    localparam int B_AIE  = 5;
    localparam int B_UIE  = 4;
    localparam int B_SQW  = 3;
    localparam int B_BIN  = 2;
    localparam int B_24H  = 1;
    localparam int B_DST  = 0;
    localparam logic [DW-1:0] B_SOFT_CLR = 8'h68;

    // status bit positions
    localparam int S_IRQ  = 7;
    localparam int S_PF   = 6;
    localparam int S_AF   = 5;
    localparam int S_UF   = 4;

    typedef enum logic [2:0] {
        SEL_RAM, SEL_CTLA, SEL_CTLB, SEL_EVST, SEL_VLD
    } sel_t;

    typedef struct packed {
        logic          wr;
        logic          rd;
        logic          odd;
        logic [DW-1:0] data;
    } host_op_t;

    function automatic sel_t decode_idx(input logic [IDX_W-1:0] idx);
        case (idx)
            IDX_CTLA: return SEL_CTLA;
            IDX_CTLB: return SEL_CTLB;
            IDX_EVST: return SEL_EVST;
            IDX_VLD:  return SEL_VLD;
            default:  return SEL_RAM;
        endcase
    endfunction
endpackage

// File: rtl/rtcp_index.sv
module rtcp_index
    import rtcp_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [IDX_W-1:0] idx_in,
    output logic [IDX_W-1:0] idx_q,
    output sel_t             sel
);
    always_ff @(posedge clk) begin
        if (rst)       idx_q <= '0;
        else if (load) idx_q <= idx_in;
    end

    assign sel = decode_idx(idx_q);
endmodule

// File: rtl/rtcp_ram.sv
module rtcp_ram
    import rtcp_pkg::*;
#(
    parameter int N = DEPTH,
    localparam int AW = $clog2(N)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [N];

    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
    end

    assign rdata = mem[addr];
endmodule

// File: rtl/rtcp_ctrl.sv
module rtcp_ctrl
    import rtcp_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          soft_rst,
    input  logic          wr_a,
    input  logic          wr_b,
    input  logic [DW-1:0] wdata,
    input  logic          uip_set,
    input  logic          uip_clr,
    output logic [DW-1:0] a_q,
    output logic [DW-1:0] b_q
);
    logic [DW-2:0] a_low;
    logic          uip_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            a_low <= CTLA_INIT[DW-2:0];
            uip_q <= CTLA_INIT[DW-1];
            b_q   <= CTLB_INIT;
        end else if (soft_rst) begin
            b_q   <= b_q & ~B_SOFT_CLR;
        end else begin
            if (wr_a) a_low <= wdata[DW-2:0];
            if (wr_b) begin
                if (wdata[B_SET]) b_q <= wdata & ~(DW'(1) << B_UIE);
                else              b_q <= wdata;
            end
            if ((wr_b && wdata[B_SET]) || uip_clr) uip_q <= 1'b0;
            else if (uip_set && !b_q[B_SET])       uip_q <= 1'b1;
        end
    end

    assign a_q = {uip_q, a_low};
endmodule

// File: rtl/rtcp_status.sv
module rtcp_status
    import rtcp_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          soft_rst,
    input  logic          rd_clr,
    input  logic          uf_set,
    input  logic          af_set,
    input  logic          pf_set,
    input  logic          pie,
    input  logic          aie,
    input  logic          uie,
    output logic [DW-1:0] c_q
);
    logic          pf_hit, af_hit, irq_hit;
    logic [DW-1:0] set_bits;

    always_comb begin
        pf_hit   = pf_set && pie;
        af_hit   = af_set && aie;
        irq_hit  = pf_hit || af_hit || (uf_set && uie);
        set_bits = '0;
        set_bits[S_IRQ] = irq_hit;
        set_bits[S_PF]  = pf_hit;
        set_bits[S_AF]  = af_hit;
        set_bits[S_UF]  = uf_set;
    end

    always_ff @(posedge clk) begin
        if (rst || soft_rst) c_q <= '0;
        else if (rd_clr)     c_q <= set_bits;
        else                 c_q <= c_q | set_bits;
    end
endmodule

// File: rtl/rtcp_regport.sv
module rtcp_regport
    import rtcp_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          soft_rst,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic          bus_odd,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic          uip_set,
    input  logic          uip_clr,
    input  logic          uf_set,
    input  logic          af_set,
    input  logic          pf_set,
    output logic [3:0]    rate_sel,
    output logic [2:0]    osc_sel,
    output logic          set_mode,
    output logic          pie_en,
    output logic          aie_en,
    output logic          uie_en,
    output logic          sqw_en,
    output logic          bin_mode,
    output logic          hr24_mode,
    output logic          dst_en,
    output logic          uip,
    output logic          irq
);
    host_op_t         op;
    logic [IDX_W-1:0] idx_q;
    sel_t             sel;
    logic [DW-1:0]    a_q, b_q, c_q, ram_q;
    logic             data_wr, data_rd;

    assign op      = '{wr: bus_wr, rd: bus_rd, odd: bus_odd, data: bus_wdata};
    assign data_wr = op.wr && op.odd;
    assign data_rd = op.rd && op.odd;

    rtcp_index u_index (
        .clk    (clk),
        .rst    (rst),
        .load   (op.wr && !op.odd),
        .idx_in (op.data[IDX_W-1:0]),
        .idx_q  (idx_q),
        .sel    (sel)
    );

    rtcp_ram #(.N(DEPTH)) u_ram (
        .clk   (clk),
        .we    (data_wr && sel == SEL_RAM),
        .addr  (idx_q),
        .wdata (op.data),
        .rdata (ram_q)
    );

    rtcp_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .soft_rst (soft_rst),
        .wr_a     (data_wr && sel == SEL_CTLA),
        .wr_b     (data_wr && sel == SEL_CTLB),
        .wdata    (op.data),
        .uip_set  (uip_set),
        .uip_clr  (uip_clr),
        .a_q      (a_q),
        .b_q      (b_q)
    );

    rtcp_status u_status (
        .clk      (clk),
        .rst      (rst),
        .soft_rst (soft_rst),
        .rd_clr   (data_rd && sel == SEL_EVST),
        .uf_set   (uf_set),
        .af_set   (af_set),
        .pf_set   (pf_set),
        .pie      (b_q[B_PIE]),
        .aie      (b_q[B_AIE]),
        .uie      (b_q[B_UIE]),
        .c_q      (c_q)
    );

    always_comb begin
        if (!op.odd) bus_rdata = IDX_READ;
        else begin
            case (sel)
                SEL_CTLA: bus_rdata = a_q;
                SEL_CTLB: bus_rdata = b_q;
                SEL_EVST: bus_rdata = c_q;
                SEL_VLD:  bus_rdata = VLD_VAL;
                default:  bus_rdata = ram_q;
            endcase
        end
    end

    assign rate_sel  = a_q[3:0];
    assign osc_sel   = a_q[6:4];
    assign uip       = a_q[DW-1];
    assign set_mode  = b_q[B_SET];
    assign pie_en    = b_q[B_PIE];
    assign aie_en    = b_q[B_AIE];
    assign uie_en    = b_q[B_UIE];
    assign sqw_en    = b_q[B_SQW];
    assign bin_mode  = b_q[B_BIN];
    assign hr24_mode = b_q[B_24H];
    assign dst_en    = b_q[B_DST];
    assign irq       = c_q[S_IRQ];
endmodule

// File: rtl/rtcp_regport_chk.sv
module rtcp_regport_chk
    import rtcp_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             soft_rst,
    input logic             bus_wr,
    input logic             bus_rd,
    input logic             bus_odd,
    input logic [DW-1:0]    bus_rdata,
    input logic [IDX_W-1:0] idx_q,
    input logic             uip_set,
    input logic             uip_clr,
    input logic             uf_set,
    input logic             af_set,
    input logic             pf_set,
    input logic [3:0]       rate_sel,
    input logic [2:0]       osc_sel,
    input logic             set_mode,
    input logic             pie_en,
    input logic             aie_en,
    input logic             uie_en,
    input logic             sqw_en,
    input logic             hr24_mode,
    input logic             uip,
    input logic             irq
);
    logic any_evt;
    assign any_evt = uf_set || af_set || pf_set;

    // R2
    even_read_ff_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && !bus_odd) |-> bus_rdata == IDX_READ);

    // R6
    evst_read_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_odd && idx_q == IDX_EVST && !any_evt && !soft_rst) |=> !irq);

    // R5
    set_blocks_uie_chk: assert property (@(posedge clk) disable iff (rst)
        set_mode |-> !uie_en);

    // R8
    soft_clear_chk: assert property (@(posedge clk) disable iff (rst)
        soft_rst |=> (!pie_en && !aie_en && !sqw_en && !irq));

    // R9
    irq_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(any_evt));

    // R3
    uip_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_odd && idx_q == IDX_CTLA && !uip_set && !uip_clr) |=> $stable(uip));

    // R7
    por_value_chk: assert property (@(posedge clk)
        rst |=> (rate_sel == 4'h6 && osc_sel == 3'h2 && hr24_mode && !set_mode && !uip && !irq));
endmodule

bind rtcp_regport rtcp_regport_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .soft_rst  (soft_rst),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_odd   (bus_odd),
    .bus_rdata (bus_rdata),
    .idx_q     (idx_q),
    .uip_set   (uip_set),
    .uip_clr   (uip_clr),
    .uf_set    (uf_set),
    .af_set    (af_set),
    .pf_set    (pf_set),
    .rate_sel  (rate_sel),
    .osc_sel   (osc_sel),
    .set_mode  (set_mode),
    .pie_en    (pie_en),
    .aie_en    (aie_en),
    .uie_en    (uie_en),
    .sqw_en    (sqw_en),
    .hr24_mode (hr24_mode),
    .uip       (uip),
    .irq       (irq)
);

// File: tb/rtcp_regport_tb.sv
`timescale 1ns/1ps
module rtcp_regport_tb_top;
    logic       clk = 1'b0;
    logic       rst, soft_rst;
    logic       bus_wr, bus_rd, bus_odd;
    logic [7:0] bus_wdata, bus_rdata;
    logic       uip_set, uip_clr, uf_set, af_set, pf_set;
    logic [3:0] rate_sel;
    logic [2:0] osc_sel;
    logic       set_mode, pie_en, aie_en, uie_en, sqw_en, bin_mode, hr24_mode, dst_en, uip, irq;

    int n_chk  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    rtcp_regport dut_i (.*);

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    task automatic bus_write(input logic odd, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_odd = odd; bus_wdata = d;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic odd, output logic [7:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_odd = odd;
        #1 d = bus_rdata;
        @(posedge clk); #1;
        bus_rd = 1'b0;
    endtask

    task automatic reg_wr(input logic [7:0] idx, input logic [7:0] d);
        bus_write(1'b0, idx);
        bus_write(1'b1, d);
    endtask

    task automatic reg_rd(input logic [7:0] idx, output logic [7:0] d);
        bus_write(1'b0, idx);
        bus_read(1'b1, d);
    endtask

    task automatic pulse(input int which);
        @(negedge clk);
        case (which)
            0: uip_set = 1'b1;
            1: uip_clr = 1'b1;
            2: uf_set  = 1'b1;
            3: af_set  = 1'b1;
            4: pf_set  = 1'b1;
            default: soft_rst = 1'b1;
        endcase
        @(posedge clk); #1;
        {uip_set, uip_clr, uf_set, af_set, pf_set, soft_rst} = '0;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        reg_rd(8'd10, v); check("R7 ctla", v, 8'h26);
        reg_rd(8'd11, v); check("R7 ctlb", v, 8'h02);
        reg_rd(8'd13, v); check("R7 vld", v, 8'h80);
        reg_rd(8'd12, v); check("R7 evst", v, 8'h00);
        check("R7 irq", irq, 0);
        check("R11 rate_sel", rate_sel, 4'h6);
        check("R11 osc_sel", osc_sel, 3'h2);
        check("R11 hr24", hr24_mode, 1);
    endtask

    task automatic t_ram();
        logic [7:0] v;
        reg_wr(8'h85, 8'h5A);
        reg_wr(8'h40, 8'hC3);
        reg_rd(8'h05, v); check("R1 idx5", v, 8'h5A);
        reg_rd(8'h40, v); check("R1 idx64", v, 8'hC3);
        bus_read(1'b0, v); check("R2 even read", v, 8'hFF);
    endtask

    task automatic t_ctla();
        logic [7:0] v;
        reg_wr(8'd10, 8'hFF);
        reg_rd(8'd10, v); check("R3 uip write ignored", v, 8'h7F);
        check("R11 rate_sel all", rate_sel, 4'hF);
        check("R11 osc_sel all", osc_sel, 3'h7);
        pulse(0);
        reg_rd(8'd10, v); check("R3 uip set", v, 8'hFF);
        reg_wr(8'd10, 8'h26);
        reg_rd(8'd10, v); check("R3 uip kept on write", v, 8'hA6);
        pulse(1);
        reg_rd(8'd10, v); check("R3 uip clear", v, 8'h26);
    endtask

    task automatic t_readonly();
        logic [7:0] v;
        pulse(2);
        reg_wr(8'd12, 8'hFF);
        reg_rd(8'd12, v); check("R4 evst write ignored", v, 8'h10);
        check("R9 uf without uie no irq", irq, 0);
        reg_wr(8'd13, 8'h00);
        reg_rd(8'd13, v); check("R4 vld write ignored", v, 8'h80);
    endtask

    task automatic t_setmode();
        logic [7:0] v;
        reg_wr(8'd11, 8'h12);
        reg_rd(8'd11, v); check("R11 ctlb", v, 8'h12);
        check("R11 uie_en", uie_en, 1);
        pulse(0);
        check("R3 uip via strobe", uip, 1);
        reg_wr(8'd11, 8'h92);
        reg_rd(8'd11, v); check("R5 uie forced off", v, 8'h82);
        check("R5 uip cleared", uip, 0);
        pulse(0);
        check("R3 uip held off in set mode", uip, 0);
        reg_wr(8'd11, 8'h02);
    endtask

    task automatic t_flags();
        logic [7:0] v;
        reg_wr(8'd11, 8'h72);
        pulse(4);
        check("R9 pf irq", irq, 1);
        reg_rd(8'd12, v); check("R6 read value", v, 8'hC0);
        check("R6 irq dropped", irq, 0);
        reg_rd(8'd12, v); check("R6 cleared", v, 8'h00);
        pulse(3);
        reg_rd(8'd12, v); check("R9 alarm", v, 8'hA0);
        pulse(2);
        reg_rd(8'd12, v); check("R9 update with uie", v, 8'h90);
        reg_wr(8'd11, 8'h02);
        pulse(4); pulse(3);
        check("R9 disabled irq", irq, 0);
        reg_rd(8'd12, v); check("R9 disabled flags", v, 8'h00);
    endtask

    task automatic t_race();
        logic [7:0] v;
        reg_wr(8'd11, 8'h12);
        bus_write(1'b0, 8'd12);
        @(negedge clk);
        bus_rd = 1'b1; bus_odd = 1'b1; uf_set = 1'b1;
        #1 v = bus_rdata;
        @(posedge clk); #1;
        bus_rd = 1'b0; uf_set = 1'b0;
        check("R10 old value returned", v, 8'h00);
        check("R10 irq survives", irq, 1);
        bus_read(1'b1, v); check("R10 flag survives", v, 8'h90);
    endtask

    task automatic t_soft();
        logic [7:0] v;
        reg_wr(8'd11, 8'h7A);
        pulse(4);
        check("R8 irq before", irq, 1);
        pulse(5);
        check("R8 irq low", irq, 0);
        reg_rd(8'd11, v); check("R8 ctlb", v, 8'h12);
        reg_rd(8'd12, v); check("R8 evst", v, 8'h00);
    endtask

    initial begin
        #(5.0 * 100000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        rst = 1'b1; soft_rst = 1'b0;
        bus_wr = 1'b0; bus_rd = 1'b0; bus_odd = 1'b0; bus_wdata = '0;
        {uip_set, uip_clr, uf_set, af_set, pf_set} = '0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        t_reset();
        t_ram();
        t_ctla();
        t_readonly();
        t_setmode();
        t_flags();
        t_race();
        t_soft();
        finish_run();
    end
endmodule